// File: doc/BRIEF.md
# Byte-Lane Static Memory Core

This block models a word-organised static memory. It has one shared bidirectional data bus that is split into two byte lanes. Two chip selects of opposite polarity must both be asserted before the memory does anything. Each byte lane has its own active-low lane control, so either lane can be read or written alone while the other lane floats. A write strobe and an output enable, both active low, choose between writing, reading and staying quiet.

Control decoding is purely combinational. Read data appears on the enabled lanes as soon as the controls and the address settle. A write is committed into the storage array on the rising edge of the block's sampling clock while the write condition holds. This lets the array map onto ordinary registers.

The depth is a parameter, and the address width follows from it. The default depth of 1024 words keeps the model small. Reset clears every stored word to zero.

Top module: `lane_sram`

## Requirements
- R1: While reset is asserted, every word is cleared to zero. After reset, a read of any address returns 0x0000 on the enabled lanes.
- R2: The memory is selected only when `cs_lo_n` is 0 and `cs_hi` is 1. In any other combination, both lanes of `dq` are high-impedance and no clock edge changes the stored data.
- R3: When `lane_n` is 2'b11, both lanes of `dq` are high-impedance and no write happens, whatever the other inputs are.
- R4: A lane is written at a rising `clk` edge when the memory is selected, `we_n` is 0 and that lane's `lane_n` bit is 0. After that edge, a read of the same address returns the byte that was on `dq` for that lane at the edge.
- R5: `lane_n[0]` gates the lower lane, `dq[7:0]`, and `lane_n[1]` gates the upper lane, `dq[15:8]`. A write to one lane leaves the other lane's stored byte unchanged.
- R6: When the memory is selected with `we_n` = 1 and `oe_n` = 0, each lane whose `lane_n` bit is 0 drives its stored byte for the current address in the same cycle. A lane whose bit is 1 stays high-impedance.
- R7: When the memory is selected with `we_n` = 1 and `oe_n` = 1, both lanes stay high-impedance.
- R8: While `we_n` is 0, the memory drives no lane, even when `oe_n` is 0.
- R9: Every address from 0 to DEPTH-1 holds its own word. A write to one address leaves every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the storage |
| addr | input | AW = clog2(DEPTH) | Word address, held stable for the whole write |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| lane_n | input | 2 | Lane controls, active low; bit 0 is the lower lane, bit 1 the upper lane |
| we_n | input | 1 | Write strobe, active low; has priority over output enable |
| oe_n | input | 1 | Output enable, active low |
| dq | inout | 16 | Shared data bus; driven per lane only while that lane is read |

## Verification
On every cycle, the assertions check the decoding rules. A deselected memory or an all-high lane control never reads or writes. A lane with its control high is never touched. The write strobe or a high output enable always blocks the drivers. A write commits the bus byte at the addressed word. Only the bench's scenarios can show what the bus carries. They check that lanes really float, that stored bytes survive a write to the other lane or a blocked write, and that separate addresses, including the top address, do not alias.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

  // Per-lane operating state produced by the control decode
  typedef enum logic [1:0] {
    LANE_IDLE  = 2'd0,
    LANE_READ  = 2'd1,
    LANE_WRITE = 2'd2
  } lane_mode_e;

endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
  import lane_sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_lo_n,
  input  logic             cs_hi,
  input  logic [LANES-1:0] lane_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic [LANES-1:0] rd_en,
  output logic [LANES-1:0] wr_en
);

  logic chip_on;
  assign chip_on = ~cs_lo_n & cs_hi;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_mode_e mode;

    // Write strobe outranks output enable so the bus is never driven
    // while the lane is accepting data.
    always_comb begin
      mode = LANE_IDLE;
      if (chip_on && !lane_n[g]) begin
        if (!we_n)      mode = LANE_WRITE;
        else if (!oe_n) mode = LANE_READ;
      end
    end

    assign rd_en[g] = (mode == LANE_READ);
    assign wr_en[g] = (mode == LANE_WRITE);
  end

endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  // One independent bank per lane: a lane write touches only its bank.
  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      end else if (wr_en[g]) begin
        bank[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[addr];
  end

endmodule

// File: rtl/lane_sram.sv
module lane_sram #(
  parameter int DEPTH  = 1024,
  parameter int LANE_W = 8,
  localparam int LANES = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          cs_lo_n,
  input  logic          cs_hi,
  input  logic [1:0]    lane_n,
  input  logic          we_n,
  input  logic          oe_n,
  inout  wire  [15:0]   dq
);

  logic [LANES-1:0] rd_en;
  logic [LANES-1:0] wr_en;
  logic [DW-1:0]    rdata;
  logic [DW-1:0]    din;

  assign din = dq;

  lane_sram_decode #(.LANES(LANES)) u_decode (
    .cs_lo_n (cs_lo_n),
    .cs_hi   (cs_hi),
    .lane_n  (lane_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en)
  );

  lane_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (din),
    .rdata (rdata)
  );

  // Per-lane tri-state drivers
  for (genvar g = 0; g < LANES; g++) begin : g_drv
    assign dq[g*LANE_W +: LANE_W] = rd_en[g] ? rdata[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};
  end

endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk #(
  parameter int LANES = 2,
  parameter int LANE_W = 8,
  parameter int AW = 10,
  localparam int DW = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             cs_lo_n,
  input logic             cs_hi,
  input logic [LANES-1:0] lane_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [LANES-1:0] rd_en,
  input logic [LANES-1:0] wr_en,
  input logic [DW-1:0]    rdata,
  input logic [DW-1:0]    din
);

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_lo_n && cs_hi) |-> (rd_en == '0 && wr_en == '0));

  // R3
  lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_n == '1) |-> (rd_en == '0 && wr_en == '0));

  // R5
  lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en | wr_en) & lane_n) == '0);

  // R7
  oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && we_n) |-> (rd_en == '0));

  // R8
  we_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (rd_en == '0));

  // R4
  lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en[0]) && $stable(addr))
      |-> (rdata[LANE_W-1:0] == $past(din[LANE_W-1:0])));

  // R4
  hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en[1]) && $stable(addr))
      |-> (rdata[DW-1:LANE_W] == $past(din[DW-1:LANE_W])));

endmodule

bind lane_sram lane_sram_chk #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .cs_lo_n (cs_lo_n),
  .cs_hi   (cs_hi),
  .lane_n  (lane_n),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .rdata   (rdata),
  .din     (din)
);

// File: tb/test_lane_sram.sv
`timescale 1ns/1ps
module test_lane_sram;

  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs_lo_n = 1'b1;
  logic          cs_hi = 1'b0;
  logic [1:0]    lane_n = 2'b11;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          tb_oe = 1'b0;
  logic [15:0]   tb_dq = '0;
  tri0  [15:0]   dq;

  // Undriven bus bits read as 0 through the pull-down, so a floating
  // lane is seen as 8'h00 where the stored byte is nonzero.
  assign dq = tb_oe ? tb_dq : 16'bz;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_sram #(.DEPTH(DEPTH)) i_lane_sram (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .cs_lo_n (cs_lo_n),
    .cs_hi   (cs_hi),
    .lane_n  (lane_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dq      (dq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Write cycle: controls set after a falling edge, committed at the next rising edge
  task automatic wr(input logic [AW-1:0] a, input logic slo, input logic shi,
                    input logic [1:0] ln, input logic [15:0] d);
    @(negedge clk);
    addr = a; cs_lo_n = slo; cs_hi = shi; lane_n = ln;
    oe_n = 1'b1; we_n = 1'b0; tb_dq = d; tb_oe = 1'b1;
    @(negedge clk);
    we_n = 1'b1; lane_n = 2'b11; tb_oe = 1'b0;
  endtask

  // Combinational access: sampled 1 ns after the controls settle, before the next rising edge
  task automatic rd(input logic [AW-1:0] a, input logic slo, input logic shi,
                    input logic [1:0] ln, input logic w, input logic o,
                    output logic [15:0] q);
    @(negedge clk);
    addr = a; cs_lo_n = slo; cs_hi = shi; lane_n = ln; tb_oe = 1'b0;
    we_n = w; oe_n = o;
    #1;
    q = dq;
    #0.5;
    we_n = 1'b1; oe_n = 1'b1; lane_n = 2'b11;
  endtask

  task automatic t_reset();
    logic [15:0] q;
    rd('0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R1 addr0 after reset", q, 16'h0000);
    rd(AW'(DEPTH-1), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R1 top addr after reset", q, 16'h0000);
  endtask

  task automatic t_full_word();
    logic [15:0] q;
    wr(AW'(5), 1'b0, 1'b1, 2'b00, 16'h1234);
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R4 full word write/read", q, 16'h1234);
  endtask

  task automatic t_lane_write();
    logic [15:0] q;
    wr(AW'(5), 1'b0, 1'b1, 2'b10, 16'h77AB);
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R5 lower lane only write", q, 16'h12AB);
    wr(AW'(5), 1'b0, 1'b1, 2'b01, 16'hCD55);
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R5 upper lane only write", q, 16'hCDAB);
  endtask

  task automatic t_lane_read();
    logic [15:0] q;
    rd(AW'(5), 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, q);
    chk("R6 lower lane only read", q, 16'h00AB);
    rd(AW'(5), 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, q);
    chk("R6 upper lane only read", q, 16'hCD00);
  endtask

  task automatic t_deselect();
    logic [15:0] q;
    for (int c = 0; c < 4; c++) begin
      if (c != 1) begin  // c[1]=cs_lo_n, c[0]=cs_hi; c==1 is selected
        rd(AW'(5), c[1], c[0], 2'b00, 1'b1, 1'b0, q);
        chk($sformatf("R2 deselect read cs=%0d", c), q, 16'h0000);
        wr(AW'(5), c[1], c[0], 2'b00, 16'hFFFF);
      end
    end
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R2 deselected writes ignored", q, 16'hCDAB);
    rd(AW'(5), 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, q);
    chk("R3 both lanes off read", q, 16'h0000);
    wr(AW'(5), 1'b0, 1'b1, 2'b11, 16'h0F0F);
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R3 both lanes off write ignored", q, 16'hCDAB);
  endtask

  task automatic t_oe_high();
    logic [15:0] q;
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, q);
    chk("R7 output enable high floats", q, 16'h0000);
  endtask

  task automatic t_we_priority();
    logic [15:0] q;
    // we_n low with oe_n low; strobe released before the rising edge
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, q);
    chk("R8 no drive while write strobe low", q, 16'h0000);
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R8 data intact after strobe pulse", q, 16'hCDAB);
  endtask

  task automatic t_addresses();
    logic [15:0] q;
    wr('0, 1'b0, 1'b1, 2'b00, 16'h1111);
    wr(AW'(DEPTH-1), 1'b0, 1'b1, 2'b00, 16'hEEEE);
    rd('0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R9 addr0 word", q, 16'h1111);
    rd(AW'(DEPTH-1), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R9 top addr word", q, 16'hEEEE);
    rd(AW'(5), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R9 other addr untouched", q, 16'hCDAB);
    rd(AW'(DEPTH/2), 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, q);
    chk("R9 unwritten addr still zero", q, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_word();
    t_lane_write();
    t_lane_read();
    t_deselect();
    t_oe_high();
    t_we_priority();
    t_addresses();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule